// File: doc/BRIEF.md
# Burst Bus Initiator Sequencer

This block is the initiator side of a shared parallel bus that uses active-low framing and handshake strobes. A local client hands it one transaction at a time: a start address, a 4-bit command, a word count and, for writes, a stream of data words. The sequencer runs a one-cycle address phase and then one data phase per word. It negates the frame strobe together with the initiator-ready strobe of the final word, and it returns the bus to idle when it is done. Bus ownership is assumed to be granted already.

The request and the write data arrive over valid/ready handshakes. A request is taken only while the sequencer is idle. A write word is taken only in a cycle where the sequencer can commit it to the bus on the next cycle. A write source that holds `wr_valid` low, or a local stall input, makes the initiator add wait states by keeping initiator-ready negated. Read words come back as a one-cycle valid strobe that the consumer cannot back-pressure. A consumer that needs to pause uses the local stall input instead. Each transaction ends with a one-cycle `done` pulse. `done_err` is high with that pulse when the transaction was aborted or no target claimed it.

All bus outputs are registered. The address/data bus is split into an output, an input and an output-enable.

Top module: `burst_initiator`

## Requirements
- R1: While idle, including right after reset, `req_ready` is 1, `frame_n` and `irdy_n` are 1 and `ad_oe` is 0. In the cycle after a request handshake, the address phase is driven for exactly one cycle: `frame_n`=0, `irdy_n`=1, `ad_o`=address, `cbe_n`=command, `ad_oe`=1. Command bit 0 set to 1 means write and 0 means read. `req_len` is the number of words minus one.
- R2: In every data-phase cycle, `cbe_n` is 4'b0000 (all bytes enabled) and `ad_oe` is 1 for a write and 0 for a read.
- R3: Once `irdy_n` is 0, `frame_n` and `irdy_n` keep their values until a clock edge that samples `irdy_n`=0 and `trdy_n`=0, whatever `trdy_n` did before.
- R4: While `irdy_n` is 0, `frame_n` is 1 exactly when the word being offered is the last word of the transaction. A one-word transfer therefore has `frame_n`=1 from its first data cycle in which `irdy_n` is 0.
- R5: `irdy_n` stays 1 in the cycle after an uncommitted cycle in which `loc_hold` was 1, or in which a write had `wr_valid`=0. A write word accepted through `wr_valid`&`wr_ready` is on `ad_o` with `irdy_n`=0 in the next cycle. Words go out in the order they were accepted.
- R6: For a read, the cycle after each completing edge has `rd_valid`=1 and `rd_data` equal to `ad_i` sampled at that edge. `rd_valid` is 0 in every other cycle.
- R7: In the cycle after the final word completes, `done`=1, `done_err`=0, `frame_n`=`irdy_n`=1 and `ad_oe`=0. `done` is 0 during the transaction.
- R8: `abort` sampled high at the address-phase edge or at a data-phase edge ends the transaction. The next cycle is idle with `done`=1 and `done_err`=1.
- R9: If `devsel_n` is not sampled low at any of the first 5 data-phase edges, the transaction ends as in R8. A claim at the 5th edge is still in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | DW | Start address |
| req_cmd | input | 4 | Bus command; bit 0 = 1 selects write |
| req_len | input | LW | Word count minus one |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word can be committed |
| wr_data | input | DW | Write word |
| loc_hold | input | 1 | Local stall, adds initiator wait states |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word |
| done | output | 1 | Transaction end pulse |
| done_err | output | 1 | Error status, valid with done |
| abort | input | 1 | Terminate current transaction |
| frame_n | output | 1 | Transaction frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target claimed the transaction, active low |
| cbe_n | output | 4 | Command / byte enables, active low |
| ad_o | output | DW | Address/data out |
| ad_oe | output | 1 | Address/data output enable |
| ad_i | input | DW | Address/data in |

## Verification
Assertions check every cycle that the strobes stay frozen while a word is offered but not yet taken. They also check that the frame strobe is negated only with initiator-ready asserted, that byte enables are zero in data phases, that the address phase lasts one cycle, that an accepted write word is committed on the next cycle, and that the bus is idle when `done` pulses. Only the bench scenarios show the word ordering and the data values. The same holds for the stall patterns, for the exact word on which the frame strobe rises, for read capture, and for the abort and claim-timeout endings, including a claim that arrives on the last allowed edge.

// File: rtl/bini_pkg.sv
package bini_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bini_state_e;
endpackage

// File: rtl/bini_dsel_timer.sv
module bini_dsel_timer #(
  parameter int LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic devsel_n,
  output logic timeout
);
  localparam int CW = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (!devsel_n) seen_q <= 1'b1;
      if (cnt_q != CW'(LIM)) cnt_q <= cnt_q + CW'(1);
    end
  end

  // fires at the LIM-th data-phase edge without any claim seen
  assign timeout = run && !seen_q && devsel_n && (cnt_q == CW'(LIM - 1));

  // R9: a claim seen during a data phase rules out a timeout afterwards
  a_r9_claim_blocks_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !devsel_n) |=> !timeout);
endmodule

// File: rtl/bini_rd_capture.sv
module bini_rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] ad_i,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= ad_i;
    end
  end
endmodule

// File: rtl/bini_seq.sv
module bini_seq
  import bini_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DW-1:0]    req_addr,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [LW-1:0]    req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  input  logic             loc_hold,
  input  logic             abort,
  input  logic             timeout,
  input  logic             trdy_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic [CMD_W-1:0] cbe_n,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  output logic             done,
  output logic             done_err,
  output logic             run,
  output logic             cap
);
  localparam int NW = LW + 1;

  bini_state_e      state_q;
  logic             frame_n_q, irdy_n_q, ad_oe_q, is_wr_q, done_q, err_q;
  logic [CMD_W-1:0] cbe_n_q;
  logic [DW-1:0]    ad_o_q;
  logic [NW-1:0]    left_q;

  logic active, word_done, kill, last_done, free, can_load, take;

  assign active    = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign word_done = (state_q == ST_DATA) && !irdy_n_q && !trdy_n;
  assign kill      = active && (abort || timeout);
  assign last_done = word_done && (left_q == '0);
  assign free      = (state_q == ST_ADDR) || irdy_n_q || word_done;
  assign can_load  = active && !kill && (left_q != '0) && !loc_hold && free;
  assign take      = can_load && (!is_wr_q || wr_valid);

  assign req_ready = (state_q == ST_IDLE);
  assign wr_ready  = can_load && is_wr_q;
  assign run       = (state_q == ST_DATA);
  assign cap       = word_done && !is_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      frame_n_q <= 1'b1;
      irdy_n_q  <= 1'b1;
      cbe_n_q   <= '1;
      ad_o_q    <= '0;
      ad_oe_q   <= 1'b0;
      is_wr_q   <= 1'b0;
      left_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q   <= ST_ADDR;
            frame_n_q <= 1'b0;
            irdy_n_q  <= 1'b1;
            ad_o_q    <= req_addr;
            cbe_n_q   <= req_cmd;
            ad_oe_q   <= 1'b1;
            is_wr_q   <= req_cmd[0];
            left_q    <= {1'b0, req_len} + NW'(1);
            err_q     <= 1'b0;
          end
        end
        default: begin
          if (kill || last_done) begin
            state_q   <= ST_IDLE;
            frame_n_q <= 1'b1;
            irdy_n_q  <= 1'b1;
            cbe_n_q   <= '1;
            ad_oe_q   <= 1'b0;
            done_q    <= 1'b1;
            err_q     <= kill;
          end else begin
            state_q <= ST_DATA;
            cbe_n_q <= '0;
            ad_oe_q <= is_wr_q;
            if (take) begin
              irdy_n_q  <= 1'b0;
              frame_n_q <= (left_q == NW'(1));
              left_q    <= left_q - NW'(1);
              if (is_wr_q) ad_o_q <= wr_data;
            end else if (free) begin
              irdy_n_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign frame_n  = frame_n_q;
  assign irdy_n   = irdy_n_q;
  assign cbe_n    = cbe_n_q;
  assign ad_o     = ad_o_q;
  assign ad_oe    = ad_oe_q;
  assign done     = done_q;
  assign done_err = err_q;

  // R1: the address phase lasts exactly one cycle
  a_r1_addr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR) |=> (state_q != ST_ADDR));
  // R2: byte enables all asserted during data phases
  a_r2_be_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (cbe_n_q == '0));
  // R3: committed strobes frozen until the word completes
  a_r3_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n_q && trdy_n && !kill) |=> ($stable(frame_n_q) && $stable(irdy_n_q)));
  // R4: frame negated inside a transaction only with initiator ready
  a_r4_frame_with_irdy: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && frame_n_q) |-> !irdy_n_q);
  // R5: an accepted write word is committed on the next cycle
  a_r5_wr_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !irdy_n_q);
  // R7: completion pulse only with an idle bus
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (frame_n_q && irdy_n_q && !ad_oe_q));
endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
  import bini_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LW       = 4,
  parameter int DSEL_LIM = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DW-1:0]    req_addr,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [LW-1:0]    req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  input  logic             loc_hold,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic             done_err,
  input  logic             abort,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  output logic [CMD_W-1:0] cbe_n,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_i
);
  logic run, cap, timeout;

  bini_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .loc_hold(loc_hold), .abort(abort), .timeout(timeout), .trdy_n(trdy_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_o(ad_o), .ad_oe(ad_oe),
    .done(done), .done_err(done_err), .run(run), .cap(cap)
  );

  bini_dsel_timer #(.LIM(DSEL_LIM)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .devsel_n(devsel_n), .timeout(timeout)
  );

  bini_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .ad_i(ad_i),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_burst_initiator.sv
module tb_burst_initiator;
  localparam int DW = 32;
  localparam int LW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, req_valid, req_ready, wr_valid, wr_ready, loc_hold;
  logic          rd_valid, done, done_err, abort, frame_n, irdy_n, trdy_n, devsel_n, ad_oe;
  logic [DW-1:0] req_addr, wr_data, rd_data, ad_o, ad_i;
  logic [3:0]    req_cmd, cbe_n;
  logic [LW-1:0] req_len;

  burst_initiator #(.DW(DW), .LW(LW), .DSEL_LIM(5)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .loc_hold(loc_hold),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_err(done_err),
    .abort(abort), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .cbe_n(cbe_n), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i)
  );

  int vectors = 0;
  int miscompares = 0;
  int tid = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      miscompares = miscompares + 1;
      $display("FAIL R7 watchdog expired act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h (txn %0d)", rq, act, exp, tid);
    end
  endtask

  function automatic logic [31:0] wdata(input int t, input int i);
    return 32'hA500_0000 ^ (32'(t) << 8) ^ (32'(i + 1) * 32'h0101_0013);
  endfunction

  function automatic logic [31:0] rdata(input logic [31:0] a, input int i);
    return a ^ (32'(i + 1) * 32'h1357_9BDF);
  endfunction

  function automatic bit hold_at(input int hp, input int c);
    case (hp)
      0: return 1'b0;
      1: return (c % 3) == 1;
      2: return (c % 4) < 2;
      default: return (c % 2) == 0;
    endcase
  endfunction

  function automatic bit wv_at(input int hp, input int c);
    case (hp)
      0: return 1'b1;
      1: return (c % 4) != 2;
      2: return (c % 3) != 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic idle_inputs();
    req_valid = 1'b0; wr_valid = 1'b0; loc_hold = 1'b0; abort = 1'b0;
    trdy_n = 1'b1; devsel_n = 1'b1;
  endtask

  // issues a request at the current negedge; returns at the negedge of the address phase
  task automatic start(input bit wr, input int len, output logic [31:0] a);
    a = 32'h4000_0000 + 32'(tid) * 32'h40;
    req_valid = 1'b1;
    req_addr  = a;
    req_cmd   = wr ? 4'h7 : 4'h6;
    req_len   = LW'(len - 1);
    #1;
    chk(req_ready == 1'b1, "R1 req_ready idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(frame_n == 1'b0 && irdy_n == 1'b1, "R1 addr strobes", {frame_n, irdy_n}, 32'b01);
    chk(ad_o == a, "R1 addr value", ad_o, a);
    chk(cbe_n == (wr ? 4'h7 : 4'h6) && ad_oe == 1'b1, "R1 command", {ad_oe, cbe_n},
        {1'b1, (wr ? 4'h7 : 4'h6)});
  endtask

  task automatic run_txn(input bit wr, input int len, input int tw, input int hp, input int dly);
    logic [31:0] a;
    int cidx, loaded, wc;
    bit p_irdy, p_frame, p_trdy, p_hold, p_wv, p_hs, comp, fin;
    tid++;
    cidx = 0; loaded = 0; wc = 0; fin = 1'b0;
    start(wr, len, a);
    devsel_n = (dly <= 0) ? 1'b0 : 1'b1;
    trdy_n   = 1'b1;
    ad_i     = rdata(a, 0);
    loc_hold = hold_at(hp, 0);
    wr_valid = wr && wv_at(hp, 0);
    wr_data  = wdata(tid, 0);
    #1;
    p_hs = wr_valid && wr_ready;
    if (p_hs) loaded++;
    p_irdy = irdy_n; p_frame = frame_n; p_trdy = trdy_n; p_hold = loc_hold; p_wv = wr_valid;
    for (int c = 1; c < 80 && !fin; c++) begin
      @(negedge clk);
      comp = !p_irdy && !p_trdy;
      if (!wr) begin
        if (comp) chk(rd_valid && rd_data == rdata(a, cidx), "R6 read word", rd_data, rdata(a, cidx));
        else      chk(!rd_valid, "R6 no strobe", 32'(rd_valid), 32'd0);
      end
      if (comp) begin
        cidx++;
        wc = 0;
      end
      if (cidx == len) begin
        chk(done && !done_err, "R7 done ok", {done, done_err}, 32'b10);
        chk(frame_n && irdy_n && !ad_oe, "R7 bus idle", {frame_n, irdy_n, ad_oe}, 32'b110);
        fin = 1'b1;
      end else begin
        chk(!done, "R7 no early done", 32'(done), 32'd0);
        chk(cbe_n == 4'h0 && ad_oe == wr, "R2 data phase", {ad_oe, cbe_n}, {wr, 4'h0});
        if (!p_irdy && !comp)
          chk(!irdy_n && frame_n == p_frame, "R3 hold", {frame_n, irdy_n}, {p_frame, 1'b0});
        if ((p_irdy || comp) && (p_hold || (wr && !p_wv)))
          chk(irdy_n, "R5 wait state", 32'(irdy_n), 32'd1);
        if (p_hs) chk(!irdy_n, "R5 commit", 32'(irdy_n), 32'd0);
        if (!irdy_n) begin
          chk(frame_n == (cidx == len - 1), "R4 last word frame", 32'(frame_n), 32'(cidx == len - 1));
          if (wr) chk(ad_o == wdata(tid, cidx), "R5 write word", ad_o, wdata(tid, cidx));
        end
        devsel_n = (c >= dly) ? 1'b0 : 1'b1;
        trdy_n   = !((wc >= tw) && (c >= dly));
        ad_i     = rdata(a, cidx);
        loc_hold = hold_at(hp, c);
        wr_valid = wr && wv_at(hp, c);
        wr_data  = wdata(tid, loaded);
        #1;
        p_hs = wr_valid && wr_ready;
        if (p_hs) loaded++;
        p_irdy = irdy_n; p_frame = frame_n; p_trdy = trdy_n; p_hold = loc_hold; p_wv = wr_valid;
        wc++;
      end
    end
    if (!fin) chk(1'b0, "R7 transaction hung", 32'(cidx), 32'(len));
    idle_inputs();
    @(negedge clk);
    chk(!rd_valid && !done, "R6 quiet after end", {rd_valid, done}, 32'b00);
  endtask

  task automatic run_kill(input bit wr, input bit tmo, input int at);
    logic [31:0] a;
    bit kp, fin;
    string tag;
    tid++;
    tag = tmo ? "R9" : "R8";
    fin = 1'b0;
    start(wr, 4, a);
    devsel_n = tmo ? 1'b1 : 1'b0;
    trdy_n   = 1'b1;
    abort    = !tmo && (at == 0);
    loc_hold = 1'b0;
    wr_valid = wr;
    wr_data  = wdata(tid, 0);
    ad_i     = rdata(a, 0);
    kp = abort;
    for (int c = 1; c < 20 && !fin; c++) begin
      @(negedge clk);
      if (kp) begin
        chk(done && done_err, {tag, " error end"}, {done, done_err}, 32'b11);
        chk(frame_n && irdy_n && !ad_oe, {tag, " bus idle"}, {frame_n, irdy_n, ad_oe}, 32'b110);
        fin = 1'b1;
      end else begin
        chk(!done, {tag, " no early end"}, 32'(done), 32'd0);
        abort = !tmo && (c == at);
        kp = tmo ? (c == 5) : (c == at);
      end
    end
    if (!fin) chk(1'b0, {tag, " never ended"}, 32'd0, 32'd1);
    idle_inputs();
    @(negedge clk);
    chk(req_ready && !done, "R1 idle again", {req_ready, done}, 32'b10);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    req_addr = '0; req_cmd = '0; req_len = '0; wr_data = '0; ad_i = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && frame_n && irdy_n && !ad_oe && !done && !rd_valid, "R1 reset state",
        {req_ready, frame_n, irdy_n, ad_oe, done, rd_valid}, 32'b111000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int wr = 0; wr < 2; wr++)
      for (int len = 1; len <= 4; len++)
        for (int tw = 0; tw < 3; tw++)
          for (int hp = 0; hp < 4; hp++)
            run_txn(wr[0], len, tw, hp, 0);

    // R9: late but legal claim on the last allowed edge
    run_txn(1'b0, 3, 1, 0, 5);
    run_txn(1'b1, 2, 0, 1, 3);
    run_txn(1'b1, 16, 0, 2, 0);

    for (int wr = 0; wr < 2; wr++) begin
      for (int at = 0; at < 4; at++) run_kill(wr[0], 1'b0, at);
      run_kill(wr[0], 1'b1, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule